// File: doc/BRIEF.md
# Masked Vector Bitwise XOR Unit

This block computes the lane-wise exclusive OR of two packed vectors made of 32-bit lanes and produces the next value of a 512-bit destination register. The lanes are raw bit patterns: nothing is interpreted numerically and no status or exception flags exist. The caller supplies both sources, the current destination value and a set of control inputs. Those inputs choose the active vector length, the encoding mode, per-lane write masking with a merge or zeroing policy, and a scalar broadcast of the second source.

Two encoding modes exist. In the extended mode the selected length sets the number of lanes computed, and every destination bit above that length is cleared. In the legacy mode the length is fixed at 128 bits, the mask, broadcast, zeroing and length inputs have no effect, and destination bits 511:128 are carried over from the current destination. The result is registered. It is captured one clock after an input strobe and held while no strobe is given.

Top module: `mvx_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears dest_out to all zeros, whatever the other inputs are.
- R2: With in_valid high at a rising edge, dest_out takes the computed result at that edge. With in_valid low, dest_out keeps its value.
- R3: An active lane j (bits 32j+31:32j) yields src_a lane j XOR src_b lane j.
- R4: In extended mode with bcast=1 and b_is_mem=1, every active lane XORs with src_b[31:0]. With bcast=1 and b_is_mem=0, each lane uses its own src_b lane.
- R5: In extended mode with mask_en=1 and zero_sel=0, a lane inside the length whose lane_mask bit is 0 takes its dest_in value.
- R6: In extended mode with mask_en=1 and zero_sel=1, a lane inside the length whose lane_mask bit is 0 becomes zero.
- R7: In extended mode (ext_mode=1) the vlen_sel encoding 0, 1, 2 selects 128, 256 and 512 bits (4, 8 and 16 lanes), and 3 also selects 512 bits. All result bits at or above the selected length are zero.
- R8: In legacy mode (ext_mode=0), lanes 0 to 3 are src_a XOR src_b and bits 511:128 equal dest_in[511:128]. lane_mask, mask_en, zero_sel, bcast, b_is_mem and vlen_sel have no effect.
- R9: In extended mode with mask_en=0, every lane inside the length is computed regardless of lane_mask and zero_sel.
- R10: lane_mask bits for lanes at or above the active lane count have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: capture a new result this edge |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| lane_mask | input | 16 | Per-lane write mask, bit j for lane j |
| mask_en | input | 1 | 1 = apply lane_mask (extended mode only) |
| zero_sel | input | 1 | 1 = unmasked lanes become zero, 0 = keep dest_in |
| bcast | input | 1 | Broadcast request for the second source |
| b_is_mem | input | 1 | Second source comes from memory |
| vlen_sel | input | 2 | Vector length: 0=128, 1=256, 2 or 3=512 bits |
| ext_mode | input | 1 | 1 = extended encoding, 0 = legacy |
| dest_in | input | 512 | Current destination value |
| dest_out | output | 512 | Registered next destination value |

## Verification
Directed patterns separate each policy on its own. A partial mask under merge versus zeroing shows whether masked lanes take dest_in or zero. Broadcast with and without the memory flag shows whether the scalar path is wrongly taken. An all-ones dest_in at short lengths exposes upper bits that are not cleared in extended mode or not kept in legacy mode. Legacy stimulus with every control input set in its most disruptive way shows that those inputs are ignored, and a mask with only out-of-range bits set shows that such bits are ignored. Random operands then sweep every combination of length, mode, mask enable, merge/zero and broadcast flags against an independent reference model. Idle cycles with changing inputs confirm that the result is held.

// File: rtl/mvx_pkg.sv
// Shared constants for the masked vector XOR unit.
// Assumes lanes are 32-bit bit patterns and lengths are multiples of a lane.
package mvx_pkg;
    localparam int LANE_BITS  = 32;
    localparam int MAX_BITS   = 512;
    localparam int SHORT_BITS = 128;
    localparam int MID_BITS   = 256;

    // vlen_sel encoding
    typedef enum logic [1:0] {
        VL_SHORT = 2'd0,
        VL_MID   = 2'd1,
        VL_FULL  = 2'd2,
        VL_ALT   = 2'd3
    } vlen_e;
endpackage

// File: rtl/mvx_lane_ctrl.sv
// Lane control: derives per-lane in-range, write-enable and broadcast use.
// Assumes SHORT_LANES <= MID_LANES <= N_LANES. Legacy mode pins the length
// to SHORT_LANES and treats the mask as all ones.
module mvx_lane_ctrl #(
    parameter int N_LANES     = 16,
    parameter int SHORT_LANES = 4,
    parameter int MID_LANES   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_mode,
    input  logic [1:0]         vlen_sel,
    input  logic [N_LANES-1:0] lane_mask,
    input  logic               mask_en,
    input  logic               bcast,
    input  logic               b_is_mem,
    output logic [N_LANES-1:0] lane_in_range,
    output logic [N_LANES-1:0] lane_write,
    output logic               use_scalar,
    output logic               keep_upper
);
    import mvx_pkg::*;

    localparam int CNT_W = $clog2(N_LANES + 1);

    logic [CNT_W-1:0] lane_cnt;

    // Purpose: map mode and length select to a lane count.
    always_comb begin
        if (!ext_mode) begin
            lane_cnt = CNT_W'(SHORT_LANES);
        end else begin
            case (vlen_e'(vlen_sel))
                VL_SHORT: lane_cnt = CNT_W'(SHORT_LANES);
                VL_MID:   lane_cnt = CNT_W'(MID_LANES);
                default:  lane_cnt = CNT_W'(N_LANES);
            endcase
        end
    end

    // Purpose: broadcast only for extended mode with a memory operand.
    always_comb begin
        use_scalar = ext_mode && bcast && b_is_mem;
        keep_upper = !ext_mode;
    end

    genvar j;
    generate
        for (j = 0; j < N_LANES; j++) begin : g_lane
            // Purpose: lane in length, and written when unmasked or masking off.
            always_comb begin
                lane_in_range[j] = (CNT_W'(j) < lane_cnt);
                lane_write[j]    = lane_in_range[j] &&
                                   (!(ext_mode && mask_en) || lane_mask[j]);
            end
        end
    endgenerate

    // R8: legacy mode always covers exactly the short lane set
    assert_legacy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> ($countones(lane_in_range) == SHORT_LANES));

    // R9: masking disabled writes every in-range lane
    assert_nomask_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && !mask_en) |-> ((lane_write & lane_in_range) == lane_in_range));

    // R10: a lane outside the length is never written, whatever its mask bit
    assert_oor_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_write & ~lane_in_range) == '0);
endmodule

// File: rtl/mvx_lane.sv
// One lane of the datapath: XOR, mask policy and out-of-length handling.
// Assumes control inputs come from mvx_lane_ctrl for the same cycle.
module mvx_lane #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_lane,
    input  logic [W-1:0] b_lane,
    input  logic [W-1:0] b_scalar,
    input  logic [W-1:0] old_lane,
    input  logic         in_range,
    input  logic         write_en,
    input  logic         use_scalar,
    input  logic         zero_sel,
    input  logic         keep_upper,
    output logic [W-1:0] res_lane
);
    logic [W-1:0] b_pick;
    logic [W-1:0] xor_val;

    // Purpose: choose second operand and form the XOR.
    always_comb begin
        b_pick  = use_scalar ? b_scalar : b_lane;
        xor_val = a_lane ^ b_pick;
    end

    // Purpose: apply length, mask and merge/zero policy.
    always_comb begin
        if (!in_range) begin
            res_lane = keep_upper ? old_lane : '0;
        end else if (write_en) begin
            res_lane = xor_val;
        end else if (zero_sel) begin
            res_lane = '0;
        end else begin
            res_lane = old_lane;
        end
    end

    // R7: extended mode clears lanes beyond the length
    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_range && !keep_upper) |-> (res_lane == '0));

    // R8: legacy mode carries the old value beyond the length
    assert_upper_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_range && keep_upper) |-> (res_lane == old_lane));

    // R5: masked-off lane merges the old value
    assert_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && !write_en && !zero_sel) |-> (res_lane == old_lane));

    // R6: masked-off lane zeroes
    assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && !write_en && zero_sel) |-> (res_lane == '0));
endmodule

// File: rtl/mvx_unit.sv
// Top of the masked vector XOR unit: lane control, a generated row of lanes,
// and the destination register. Assumes dest_in is the architectural value
// of the destination before this operation.
module mvx_unit #(
    parameter int LANE_W  = mvx_pkg::LANE_BITS,
    parameter int DATA_W  = mvx_pkg::MAX_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [DATA_W-1:0]          src_a,
    input  logic [DATA_W-1:0]          src_b,
    input  logic [DATA_W/LANE_W-1:0]   lane_mask,
    input  logic                       mask_en,
    input  logic                       zero_sel,
    input  logic                       bcast,
    input  logic                       b_is_mem,
    input  logic [1:0]                 vlen_sel,
    input  logic                       ext_mode,
    input  logic [DATA_W-1:0]          dest_in,
    output logic [DATA_W-1:0]          dest_out
);
    import mvx_pkg::*;

    localparam int N_LANES     = DATA_W / LANE_W;
    localparam int SHORT_LANES = SHORT_BITS / LANE_W;
    localparam int MID_LANES   = MID_BITS / LANE_W;
    localparam int LEG_W       = SHORT_LANES * LANE_W;

    logic [N_LANES-1:0] lane_in_range;
    logic [N_LANES-1:0] lane_write;
    logic               use_scalar;
    logic               keep_upper;
    logic [DATA_W-1:0]  next_dest;

    mvx_lane_ctrl #(
        .N_LANES    (N_LANES),
        .SHORT_LANES(SHORT_LANES),
        .MID_LANES  (MID_LANES)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_mode     (ext_mode),
        .vlen_sel     (vlen_sel),
        .lane_mask    (lane_mask),
        .mask_en      (mask_en),
        .bcast        (bcast),
        .b_is_mem     (b_is_mem),
        .lane_in_range(lane_in_range),
        .lane_write   (lane_write),
        .use_scalar   (use_scalar),
        .keep_upper   (keep_upper)
    );

    genvar j;
    generate
        for (j = 0; j < N_LANES; j++) begin : g_lane
            mvx_lane #(.W(LANE_W)) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .a_lane    (src_a[j*LANE_W +: LANE_W]),
                .b_lane    (src_b[j*LANE_W +: LANE_W]),
                .b_scalar  (src_b[LANE_W-1:0]),
                .old_lane  (dest_in[j*LANE_W +: LANE_W]),
                .in_range  (lane_in_range[j]),
                .write_en  (lane_write[j]),
                .use_scalar(use_scalar),
                .zero_sel  (zero_sel),
                .keep_upper(keep_upper),
                .res_lane  (next_dest[j*LANE_W +: LANE_W])
            );
        end
    endgenerate

    // Purpose: destination register, cleared on reset, loaded on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_out <= '0;
        end else if (in_valid) begin
            dest_out <= next_dest;
        end
    end

    // R2: no strobe means the destination holds
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dest_out));

    // R8: legacy strobe preserves the upper destination bits
    assert_legacy_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ext_mode) |=>
            (dest_out[DATA_W-1:LEG_W] == $past(dest_in[DATA_W-1:LEG_W])));

    // R4: broadcast result lanes agree with lane zero's operand pairing
    assert_bcast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_scalar && lane_write[1]) |=>
            (dest_out[2*LANE_W-1:LANE_W] ==
             ($past(src_a[2*LANE_W-1:LANE_W]) ^ $past(src_b[LANE_W-1:0]))));
endmodule

// File: tb/mvx_unit_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver pushes expected results, monitor pops and compares.
module mvx_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src_a = '0, src_b = '0, dest_in = '0;
    logic [15:0]  lane_mask = '0;
    logic         mask_en = 1'b0, zero_sel = 1'b0, bcast = 1'b0, b_is_mem = 1'b0;
    logic [1:0]   vlen_sel = 2'd0;
    logic         ext_mode = 1'b0;
    logic [511:0] dest_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [511:0] exp;
        string        tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    mvx_unit u_mvx_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .lane_mask(lane_mask),
        .mask_en(mask_en), .zero_sel(zero_sel), .bcast(bcast),
        .b_is_mem(b_is_mem), .vlen_sel(vlen_sel), .ext_mode(ext_mode),
        .dest_in(dest_in), .dest_out(dest_out)
    );

    // Reference model written from the requirements.
    function automatic logic [511:0] ref_model(
        input logic [511:0] a, b, d, input logic [15:0] m,
        input logic men, zs, bc, mem, input logic [1:0] vl, input logic ext);
        logic [511:0] r;
        int kl;
        r = '0;
        if (!ext) begin
            r = d;
            for (int j = 0; j < 4; j++) r[j*32 +: 32] = a[j*32 +: 32] ^ b[j*32 +: 32];
        end else begin
            kl = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
            for (int j = 0; j < kl; j++) begin
                if (!men || m[j])
                    r[j*32 +: 32] = a[j*32 +: 32] ^ ((bc && mem) ? b[31:0] : b[j*32 +: 32]);
                else if (zs)
                    r[j*32 +: 32] = '0;
                else
                    r[j*32 +: 32] = d[j*32 +: 32];
            end
        end
        return r;
    endfunction

    function automatic logic [511:0] rand512();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input logic [511:0] act, input logic [511:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one operation at a falling edge and push its expectation.
    task automatic send(input logic [511:0] a, b, d, input logic [15:0] m,
                        input logic men, zs, bc, mem, input logic [1:0] vl,
                        input logic ext, input string tag);
        sb_item_t it;
        @(negedge clk);
        src_a = a; src_b = b; dest_in = d; lane_mask = m;
        mask_en = men; zero_sel = zs; bcast = bc; b_is_mem = mem;
        vlen_sel = vl; ext_mode = ext; in_valid = 1'b1;
        it.exp = ref_model(a, b, d, m, men, zs, bc, mem, vl, ext);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: after each capturing edge, pop and compare.
    initial begin
        forever begin
            bit fire;
            sb_item_t it;
            @(posedge clk);
            fire = in_valid && rst_n;
            #1;
            if (fire && sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(dest_out, it.exp, it.tag);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [511:0] a, b, d, snap;
        logic [511:0] ones;
        ones = '1;

        // R1: reset with a live strobe still leaves zero
        in_valid = 1'b1; src_a = rand512(); src_b = rand512(); ext_mode = 1'b1; vlen_sel = 2'd2;
        repeat (3) @(negedge clk);
        check(dest_out, '0, "R1 reset");
        in_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R3: full length, no masking
        a = rand512(); b = rand512();
        send(a, b, ones, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, "R3 full xor");
        send(a, b, ones, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, "R7 vlen 3 full");
        // R4: broadcast with and without memory flag
        send(rand512(), rand512(), '0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1, "R4 bcast mem");
        send(rand512(), rand512(), '0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, "R4 bcast reg");
        // R5 / R6: same partial mask, merge versus zero
        a = rand512(); b = rand512(); d = rand512();
        send(a, b, d, 16'h00F0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, "R5 merge");
        send(a, b, d, 16'h00F0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, "R6 zero");
        // R7: short lengths clear upper bits
        send(rand512(), rand512(), ones, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, "R7 len128");
        send(rand512(), rand512(), ones, 16'h0F0F, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, "R7 len256");
        // R8: legacy ignores every extended control
        send(rand512(), rand512(), rand512(), 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, "R8 legacy");
        // R9: masking off ignores mask and zero select
        send(rand512(), rand512(), rand512(), 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, "R9 nomask");
        // R10: only out-of-range mask bits set
        send(rand512(), rand512(), ones, 16'hFFF0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, "R10 oor mask");
        send(rand512(), rand512(), ones, 16'hFF00, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, "R10 oor zero");

        // R2: idle cycles with changing inputs hold the result
        @(negedge clk);
        in_valid = 1'b0;
        snap = dest_out;
        for (int k = 0; k < 3; k++) begin
            src_a = rand512(); src_b = rand512(); dest_in = rand512(); ext_mode = k[0];
            @(negedge clk);
            check(dest_out, snap, "R2 hold");
        end

        // Random sweep over all control combinations
        for (int it = 0; it < 400; it++) begin
            logic [15:0] m;
            logic men, zs, bc, mem, ext;
            logic [1:0] vl;
            string tag;
            m = 16'($urandom); men = 1'($urandom); zs = 1'($urandom);
            bc = 1'($urandom); mem = 1'($urandom); vl = 2'($urandom); ext = 1'($urandom);
            if (!ext) tag = "R8 rand";
            else if (!men) tag = "R9 rand";
            else if (bc && mem) tag = "R4 rand";
            else if (zs) tag = "R6 rand";
            else tag = "R5 rand";
            send(rand512(), rand512(), rand512(), m, men, zs, bc, mem, vl, ext, tag);
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);

        // R1: reset in mid-run clears a non-zero result
        rst_n = 1'b0;
        @(negedge clk);
        check(dest_out, '0, "R1 mid reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard: got %0d left expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule